// File: doc/BRIEF.md
# Ping-Pong Receive Frame Buffer

This block is the receive side of a small Ethernet-style controller. A byte stream of incoming frames arrives with start-of-frame and end-of-frame markers. Each frame is packed into 32-bit words and written into one of one or two frame buffers. When the frame has been fully stored and its destination field passes the address filter, the buffer's done flag is set. The buffer then belongs to software until software clears that flag.

Software reaches both buffers and their status words through a word-wide register/memory port that uses byte addresses. Filling alternates strictly between the two buffers, so software can walk them in the same order. A frame that finds its expected buffer still owned by software is discarded whole. Each buffer can also raise a one-cycle interrupt pulse when it is handed over.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset both status words read 0 (done clear, interrupt enable clear) and `irq` is low.
- R2: Frame bytes are packed most significant byte first: byte 4k+j lands in bits [31-8j:24-8j] of word k. Word k of the first buffer is at byte address 0x1000+4k. The unused tail of the last partial word reads as zero.
- R3: A frame is kept only if its first 6 bytes equal `station_addr` (the first byte compared with bits 47:40) or are all 0xFF. Any other frame, including one shorter than 6 bytes, leaves done clear and the same buffer is used for the next frame.
- R4: The status word of the first buffer is at 0x17FC. Its bit 0 (done) reads 1 from the cycle after the end-of-frame byte of a kept frame is accepted.
- R5: A write to a status word stores bit 3 as that buffer's interrupt enable. A 0 in bit 0 clears done. A 1 in bit 0 never sets done.
- R6: With `DUAL_BUF`=1 the second buffer and its status word sit 0x800 above the first (data at 0x1800, status at 0x1FFC). Kept frames fill buffer 0, buffer 1, buffer 0, and so on in strict turn.
- R7: A frame whose expected buffer still has done set is dropped entirely, even if the other buffer is free. No buffer contents or status change, and the expected buffer stays the same.
- R8: `irq` is high for exactly one cycle, in the cycle done first reads 1, and only when that buffer's enable bit was set.
- R9: With `DUAL_BUF`=0 only the first buffer exists. Addresses 0x1800–0x1FFF read 0, and a frame arriving while buffer 0 is done is dropped.
- R10: Bytes past a buffer's capacity (`BUF_WORDS`*4) are discarded but the frame is still kept. Word offsets at or beyond `BUF_WORDS` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on `in_data` this cycle |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| station_addr | input | 48 | Programmed station address, first wire byte in bits 47:40 |
| reg_addr | input | 13 | Byte address of the register/memory access |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The bench targets these corner cases:
- Expected buffer busy while the other buffer is free. A design that falls back to the free buffer would break the alternation software depends on.
- Frames that fail the filter or are shorter than 6 bytes. A design that advances the fill pointer on them would leave a gap in the order.
- A write of 1 to done on a free buffer. This must not hand over a buffer that holds no frame.
- An oversized frame, an exactly 6-byte frame, a last word that is only partly filled, and interrupts with the enable set and cleared. Wrong lane packing or missing zero fill shows up directly in the word reads.

A second instance built with a single buffer checks that the upper region stays empty and that frames are dropped while buffer 0 is held.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  // word index of the status word inside a 0x800 buffer window
  localparam logic [8:0] STAT_WIDX = 9'h1FF;
  localparam int DONE_BIT  = 0;
  localparam int IE_BIT    = 3;
  localparam int HDR_BYTES = 6;

  // place a byte into its lane, most significant lane first; lane 0 starts a fresh word
  function automatic logic [31:0] lane_merge(logic [31:0] old, logic [7:0] b, logic [1:0] lane);
    logic [31:0] w;
    w = (lane == 2'd0) ? 32'h0 : old;
    w[31-8*int'(lane) -: 8] = b;
    return w;
  endfunction

  function automatic logic [7:0] station_byte(logic [47:0] sta, int k);
    return sta[47-8*k -: 8];
  endfunction

  function automatic logic [31:0] status_word(logic done, logic ie);
    logic [31:0] w;
    w = 32'h0;
    w[DONE_BIT] = done;
    w[IE_BIT]   = ie;
    return w;
  endfunction
endpackage

// File: rtl/rxpp_dest_filter.sv
module rxpp_dest_filter
  import rxpp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_en,
  input  logic        first,
  input  logic [7:0]  byte_in,
  input  logic [47:0] station,
  output logic        pass_now
);
  logic [2:0] hdr_cnt, cnt_b, cnt_n;
  logic       st_ok, bc_ok, st_b, bc_b, st_n, bc_n;

  always_comb begin
    cnt_b = first ? 3'd0 : hdr_cnt;
    st_b  = first ? 1'b1 : st_ok;
    bc_b  = first ? 1'b1 : bc_ok;
    cnt_n = cnt_b;
    st_n  = st_b;
    bc_n  = bc_b;
    if (int'(cnt_b) < HDR_BYTES) begin
      st_n  = st_b && (byte_in == station_byte(station, int'(cnt_b)));
      bc_n  = bc_b && (byte_in == 8'hFF);
      cnt_n = cnt_b + 3'd1;
    end
    pass_now = (int'(cnt_n) == HDR_BYTES) && (st_n || bc_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_cnt <= '0;
      st_ok   <= 1'b0;
      bc_ok   <= 1'b0;
    end else if (byte_en) begin
      hdr_cnt <= cnt_n;
      st_ok   <= st_n;
      bc_ok   <= bc_n;
    end
  end

  assert_hdr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hdr_cnt) <= HDR_BYTES);
endmodule

// File: rtl/rxpp_frame_buf.sv
module rxpp_frame_buf
  import rxpp_pkg::*;
#(
  parameter int BUF_WORDS = 64,
  parameter int IDX_W     = $clog2(BUF_WORDS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_lane,
  input  logic [7:0]       wr_byte,
  input  logic             commit,
  input  logic             sw_wr,
  input  logic [31:0]      sw_wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word,
  output logic             done,
  output logic             ie,
  output logic             irq_pulse
);
  logic [31:0] mem [BUF_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= lane_merge(mem[wr_idx], wr_byte, wr_lane);
  end

  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      ie        <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      if (commit) done <= 1'b1;
      else if (sw_wr && !sw_wdata[DONE_BIT]) done <= 1'b0;
      if (sw_wr) ie <= sw_wdata[IE_BIT];
      irq_pulse <= commit && ie;
    end
  end

  assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $rose(done));
  assert_clear_by_sw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(sw_wr && !sw_wdata[DONE_BIT]));
  assert_commit_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || wr_en) |-> !done);
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf
  import rxpp_pkg::*;
#(
  parameter int DUAL_BUF  = 1,
  parameter int BUF_WORDS = 64   // power of two, 2..256
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [47:0] station_addr,
  input  logic [12:0] reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int NBUF  = (DUAL_BUF != 0) ? 2 : 1;
  localparam int CAP   = BUF_WORDS * 4;
  localparam int IDX_W = $clog2(BUF_WORDS);
  localparam int CNT_W = $clog2(CAP + 1);
  localparam logic [CNT_W-1:0] CAP_C     = CNT_W'(CAP);
  localparam logic [8:0]       WORDS_LIM = 9'(BUF_WORDS);

  // fill control
  logic             active, tgt, next_buf;
  logic [CNT_W-1:0] byte_cnt;

  // named internal events
  logic             cur_buf, capture, pass_now, commit_now;
  logic [CNT_W-1:0] cur_cnt;
  logic [1:0]       wr_en_v, commit_v, sw_wr_v, done_v, ie_v, irq_v;
  logic [31:0]      rd_word_v [2];

  // register port decode
  logic             region, bsel;
  logic [8:0]       widx;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [1:0]       wr_lane;

  assign region  = reg_addr[12];
  assign bsel    = reg_addr[11];
  assign widx    = reg_addr[10:2];
  assign rd_idx  = widx[IDX_W-1:0];

  assign cur_buf = in_sof ? next_buf : tgt;
  assign cur_cnt = in_sof ? '0 : byte_cnt;
  assign capture = in_valid && (in_sof ? !done_v[next_buf] : active);
  assign wr_idx  = cur_cnt[IDX_W+1:2];
  assign wr_lane = cur_cnt[1:0];
  assign commit_now = capture && in_eof && pass_now;

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      wr_en_v[b]  = capture && (cur_buf == 1'(b)) && (cur_cnt < CAP_C);
      commit_v[b] = commit_now && (cur_buf == 1'(b));
      sw_wr_v[b]  = reg_wr && region && (bsel == 1'(b)) && (widx == STAT_WIDX);
    end
  end

  rxpp_dest_filter u_filter (
    .clk(clk), .rst_n(rst_n), .byte_en(capture), .first(in_sof),
    .byte_in(in_data), .station(station_addr), .pass_now(pass_now)
  );

  for (genvar b = 0; b < 2; b++) begin : g_buf
    if (b < NBUF) begin : g_on
      rxpp_frame_buf #(.BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_v[b]), .wr_idx(wr_idx), .wr_lane(wr_lane), .wr_byte(in_data),
        .commit(commit_v[b]), .sw_wr(sw_wr_v[b]), .sw_wdata(reg_wdata),
        .rd_idx(rd_idx), .rd_word(rd_word_v[b]),
        .done(done_v[b]), .ie(ie_v[b]), .irq_pulse(irq_v[b])
      );
    end else begin : g_off
      // absent buffer looks permanently owned so it is never chosen
      assign done_v[b]    = 1'b1;
      assign ie_v[b]      = 1'b0;
      assign irq_v[b]     = 1'b0;
      assign rd_word_v[b] = 32'h0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      tgt      <= 1'b0;
      next_buf <= 1'b0;
      byte_cnt <= '0;
    end else begin
      if (capture) begin
        active   <= !in_eof;
        tgt      <= cur_buf;
        byte_cnt <= (cur_cnt == CAP_C) ? cur_cnt : cur_cnt + 1'b1;
      end else if (in_valid && in_sof) begin
        active <= 1'b0;   // expected buffer busy: drop the whole frame
      end
      if (commit_now) next_buf <= (NBUF == 2) ? !next_buf : 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    if (region && (bsel == 1'b0 || NBUF == 2)) begin
      if (widx == STAT_WIDX)     reg_rdata = status_word(done_v[bsel], ie_v[bsel]);
      else if (widx < WORDS_LIM) reg_rdata = rd_word_v[bsel];
    end
  end

  assign irq = |irq_v;

  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(next_buf) |-> $past(commit_now));
  assert_irq_after_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(in_valid && in_eof));
  assert_no_write_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en_v) |-> !done_v[cur_buf]);
endmodule

// File: tb/tb_rx_pingpong_buf.sv
module tb_rx_pingpong_buf;
  localparam logic [47:0] STA = 48'h02_1A_3C_4D_5E_6F;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h0;
  logic [12:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata, reg_rdata1;
  logic        irq, irq1;

  always #2 clk = ~clk;  // 250 MHz

  rx_pingpong_buf #(.DUAL_BUF(1), .BUF_WORDS(64)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .station_addr(STA), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  rx_pingpong_buf #(.DUAL_BUF(0), .BUF_WORDS(64)) dut1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .station_addr(STA), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata1), .irq(irq1));

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0]  frm [300];
  int          flen, fkind;
  logic [31:0] exp_mem [2][64];
  int          exp_len [2];
  bit          exp_done [2], exp_ie [2];
  int          exp_next;
  logic        irq_a, irq1_a, irq_b;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got cycle %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_word(int w);
    logic [31:0] v = 32'h0;
    for (int k = 0; k < 4; k++) v = {v[23:0], (4*w+k < flen) ? frm[4*w+k] : 8'h00};
    return v;
  endfunction

  task automatic rd(input logic [12:0] a, output logic [31:0] d, output logic [31:0] d1);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata; d1 = reg_rdata1;
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic set_stat(int b, logic [31:0] v);
    wr(13'h17FC + 13'(b * 'h800), v);
    exp_ie[b] = v[3];
    if (!v[0]) exp_done[b] = 1'b0;
  endtask

  // kind 0: station, 1: broadcast, 2: mismatching destination
  task automatic build(int kind, int len);
    fkind = kind; flen = len;
    for (int i = 0; i < len; i++) begin
      if (i < 6) frm[i] = (kind == 1) ? 8'hFF : STA[47-8*i -: 8];
      else frm[i] = 8'($urandom);
    end
    if (kind == 2 && len > 5) frm[5] = frm[5] ^ 8'h01;
  endtask

  task automatic drive(bit gaps);
    for (int i = 0; i < flen; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin @(negedge clk); in_valid = 1'b0; end
      @(negedge clk);
      in_valid = 1'b1; in_data = frm[i]; in_sof = (i == 0); in_eof = (i == flen - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    irq_a = irq; irq1_a = irq1;
    @(negedge clk);
    irq_b = irq;
  endtask

  task automatic send_built(bit gaps);
    int  t = exp_next;
    bit  kept = !exp_done[t] && flen >= 6 && fkind != 2;
    drive(gaps);
    if (kept) begin
      for (int w = 0; w < ((flen < 256 ? flen : 256) + 3) / 4; w++) exp_mem[t][w] = pack_word(w);
      exp_len[t] = (flen < 256) ? flen : 256;
      exp_done[t] = 1'b1;
      exp_next ^= 1;
    end
    chk("R8 irq pulse", {31'b0, irq_a}, {31'b0, kept && exp_ie[t]});
    chk("R8 irq one cycle", {31'b0, irq_b}, 32'h0);
  endtask

  task automatic check_state(string tag);
    logic [31:0] d, d1;
    for (int b = 0; b < 2; b++) begin
      rd(13'h17FC + 13'(b * 'h800), d, d1);
      chk({tag, " R4 status"}, d, {28'b0, exp_ie[b], 2'b0, exp_done[b]});
      if (exp_done[b])
        for (int w = 0; w < (exp_len[b] + 3) / 4; w++) begin
          rd(13'h1000 + 13'(b * 'h800) + 13'(4 * w), d, d1);
          chk({tag, " R2 data"}, d, exp_mem[b][w]);
        end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_next = 0;
    for (int b = 0; b < 2; b++) begin exp_done[b] = 0; exp_ie[b] = 0; exp_len[b] = 0; end
  endtask

  initial begin
    logic [31:0] d, d1, w1_first;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: reset state
    rd(13'h17FC, d, d1); chk("R1 status0", d, 32'h0); chk("R1 status0 single", d1, 32'h0);
    rd(13'h1FFC, d, d1); chk("R1 status1", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R9: single-buffer build drops while buffer 0 is held
    build(0, 8); w1_first = pack_word(1); send_built(1'b0);
    build(1, 9); send_built(1'b0);
    rd(13'h1FFC, d, d1); chk("R9 upper status empty", d1, 32'h0);
    rd(13'h17FC, d, d1); chk("R9 buffer0 held", d1, 32'h1);
    rd(13'h1004, d, d1); chk("R9 first frame kept", d1, w1_first);
    rd(13'h1800, d, d1); chk("R9 upper data empty", d1, 32'h0);
    check_state("R6 dual after two frames");
    chk("R6 second buffer used", {31'b0, exp_done[1]}, 32'h1);

    do_reset();
    set_stat(0, 32'h8); set_stat(1, 32'h8);

    // R2/R4/R8: known 10-byte frame, tail zero fill
    build(0, 10);
    frm[6] = 8'hA1; frm[7] = 8'hA2; frm[8] = 8'hA3; frm[9] = 8'hA4;
    send_built(1'b0);
    rd(13'h1000, d, d1); chk("R2 word0", d, STA[47:16]);
    rd(13'h1004, d, d1); chk("R2 word1", d, {STA[15:0], 16'hA1A2});
    rd(13'h1008, d, d1); chk("R2 zero tail", d, 32'hA3A4_0000);
    rd(13'h17FC, d, d1); chk("R4 done set", d, 32'h9);

    // R6: broadcast goes to second buffer
    build(1, 7); send_built(1'b1);
    check_state("R6");

    // R7: both busy, then only the unexpected one free
    build(0, 12); send_built(1'b0);
    check_state("R7 both busy");
    set_stat(1, 32'h8);
    build(0, 12); send_built(1'b0);
    rd(13'h1FFC, d, d1); chk("R7 other buffer not used", d, 32'h8);
    check_state("R7 expected busy");

    // R8: enable cleared, no interrupt
    set_stat(0, 32'h0);
    build(0, 20); send_built(1'b0);
    check_state("R8 ie off");

    // R5: writing 1 to done does not set it
    set_stat(1, 32'h9);
    rd(13'h1FFC, d, d1); chk("R5 done not settable", d, 32'h8);
    exp_done[1] = 1'b0;

    // R3: mismatch and short frames rejected, 6-byte frame kept
    build(2, 20); send_built(1'b0);
    rd(13'h1FFC, d, d1); chk("R3 mismatch rejected", d, 32'h8);
    build(1, 5); send_built(1'b0);
    rd(13'h1FFC, d, d1); chk("R3 short rejected", d, 32'h8);
    build(0, 6); send_built(1'b0);
    check_state("R3 six bytes");

    // R10: oversize frame
    set_stat(0, 32'h8); set_stat(1, 32'h8);
    build(0, 260); send_built(1'b0);
    check_state("R10 oversize");
    rd(13'h1100, d, d1); chk("R10 beyond capacity reads 0", d, 32'h0);

    // random frames
    for (int it = 0; it < 60; it++) begin
      int r = $urandom % 8;
      for (int b = 0; b < 2; b++)
        if ($urandom % 2 == 0) set_stat(b, {28'b0, 1'($urandom), 3'b000});
      if (r < 4)       build(0, 6 + $urandom % 70);
      else if (r < 6)  build(1, 6 + $urandom % 70);
      else if (r == 6) build(2, 6 + $urandom % 70);
      else             build(1, 1 + $urandom % 5);
      send_built(1'($urandom));
      check_state("R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule